// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Incrementing Pointer

This block is a target on a two-wire serial bus (I2C) that answers to the 7-bit address 1001101. Behind that address it holds a bank of ten 8-bit control registers, plus one fixed revision byte that can only be read. A controller first sends a pointer byte to pick a register and then streams data bytes into consecutive registers. When the controller reads, the block returns bytes starting at the pointer, and the pointer advances after every byte.

The bus lines are sampled by the system clock. Each line passes through a synchroniser and a short stability filter, so spikes do not reach the protocol logic. The block decodes START, repeated START and STOP conditions from the filtered lines. It pulls SDA low through a single drive-low output, which is meant for an open-drain pad. The full register contents are always visible on a flat parallel output.

A read that follows a plain START always begins at register 0. A read that follows a repeated START begins at the pointer that was loaded earlier in the same transaction.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset all ten registers read as 0x00 and SDA is not driven.
- R2: Only the address byte 0x9A (write) or 0x9B (read) is acknowledged. Any other address gets no acknowledge, and the bytes that follow it are ignored until the next START.
- R3: Each acknowledge pulls SDA low from the SCL falling edge after the 8th bit until the SCL falling edge after the 9th bit. This covers the address byte, the pointer byte and every written data byte.
- R4: In a write, the byte after the address loads the 8-bit pointer. Each later byte goes to the register at the pointer, and then the pointer increases by one, wrapping from 0xFF to 0x00.
- R5: A read address byte that follows a plain START (the bus was idle) returns register 0x00 first.
- R6: A pointer write, then a repeated START, then a read address byte returns the register at that pointer first. The following bytes come from successive addresses.
- R7: During a read, an acknowledge from the controller (SDA low on the 9th clock) makes the block send the next byte. A not-acknowledge makes it release SDA and stay silent until the next START.
- R8: A STOP at any point ends the transfer. A partly received data byte is discarded and leaves every register unchanged.
- R9: A STOP inside the same SCL high period as a START is ignored, so the transfer that the START began continues.
- R10: Pointer values 0x0A to 0xFF are reserved. Writes to them are acknowledged and discarded. Reads from them return 0x00, except at 0xFF, which returns the revision byte (parameter, 0x35 by default).
- R11: Pulses on SCL or SDA shorter than FILT_LEN system clocks (4 by default) have no effect on the transfer.
- R12: The SDA drive-low output changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | Register contents, register n in bits [8n+7:8n] |

## Verification
Most internal faults in this block show up on the bus within a single byte. A wrong state or bit count moves or drops the acknowledge pulse, or corrupts the serial data in the 9th clock or in the next byte that is read. A wrong pointer shows differently. On a write, it changes the wrong lane of the parallel register output one system clock after the SCL falling edge that ends the data byte. On a read, it returns a byte that differs from the modelled register at the very first byte. A fault in the pointer-reset rule between plain and repeated START only appears on the first byte after the read address, which is why both paths are driven separately.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam logic [6:0] DEV_ADDR = 7'b1001101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } eng_state_e;

    typedef struct packed {
        eng_state_e state;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       drive;
        logic       busy;
        logic       ptr_set;
        logic       rd;
        logic       nack;
        logic       st_high;
        logic       scl_p;
        logic       sda_p;
    } eng_regs_t;

endpackage

// File: rtl/i2c_rf_glitch_filter.sv
module i2c_rf_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_d, cnt_q;
    logic                   out_d, out_q;
    logic                   sampled;

    assign sampled = sync_q[SYNC_STAGES-1];

    always_comb begin
        cnt_d = cnt_q;
        out_d = out_q;
        if (sampled == out_q) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            out_d = sampled;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            out_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            cnt_q  <= cnt_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/i2c_rf_regbank.sv
module i2c_rf_regbank #(
    parameter int         NUM_REGS = 10,
    parameter logic [7:0] REV_ID   = 8'h35
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] bank_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] val_d;
        always_comb begin
            val_d = bank_q[g];
            if (wr_en && (wr_addr == 8'(g))) val_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_q[g] <= '0;
            else        bank_q[g] <= val_d;
        end
        assign regs_o[g*8 +: 8] = bank_q[g];
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == 8'(i)) rd_data = bank_q[i];
        end
        if (rd_addr == 8'hFF) rd_data = REV_ID;
    end
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
    import i2c_rf_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_drive
);
    eng_regs_t d, q;
    logic scl_rise, scl_fall, start_c, stop_c;

    assign scl_rise = scl & ~q.scl_p;
    assign scl_fall = ~scl & q.scl_p;
    assign start_c  = scl & q.scl_p & q.sda_p & ~sda;
    assign stop_c   = scl & q.scl_p & ~q.sda_p & sda;
    assign rd_addr  = (q.state == ST_ADDR_ACK && !q.ptr_set) ? 8'h00 : q.ptr;
    assign wr_addr  = q.ptr;
    assign wr_data  = q.sh;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        d.scl_p = scl;
        d.sda_p = sda;
        if (scl_fall) d.st_high = 1'b0;

        if (start_c) begin
            d.state   = ST_ADDR;
            d.cnt     = '0;
            d.drive   = 1'b0;
            d.st_high = 1'b1;
            d.busy    = 1'b1;
            if (!q.busy) d.ptr_set = 1'b0;
        end else if (stop_c && !q.st_high) begin
            d.state   = ST_IDLE;
            d.drive   = 1'b0;
            d.busy    = 1'b0;
            d.ptr_set = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.state == ST_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.drive = 1'b1;
                                d.rd    = q.sh[0];
                                d.state = ST_ADDR_ACK;
                            end else begin
                                d.state = ST_IGNORE;
                            end
                        end else if (q.state == ST_PTR) begin
                            d.ptr     = q.sh;
                            d.ptr_set = 1'b1;
                            d.drive   = 1'b1;
                            d.state   = ST_PTR_ACK;
                        end else begin
                            wr_en   = (q.ptr < 8'(NUM_REGS));
                            d.ptr   = q.ptr + 8'd1;
                            d.drive = 1'b1;
                            d.state = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.ptr   = rd_addr;
                            d.drive = ~rd_data[7];
                            d.sh    = {rd_data[6:0], 1'b0};
                            d.state = ST_RDATA;
                        end else begin
                            d.drive = 1'b0;
                            d.state = ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.drive = 1'b0;
                        d.cnt   = '0;
                        d.state = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.drive = 1'b0;
                            d.ptr   = q.ptr + 8'd1;
                            d.state = ST_RACK;
                        end else begin
                            d.drive = ~q.sh[7];
                            d.sh    = {q.sh[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.nack = sda;
                    end else if (scl_fall) begin
                        if (!q.nack) begin
                            d.cnt   = '0;
                            d.drive = ~rd_data[7];
                            d.sh    = {rd_data[6:0], 1'b0};
                            d.state = ST_RDATA;
                        end else begin
                            d.state = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_drive = q.drive;
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
    parameter int         NUM_REGS    = 10,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 4,
    parameter logic [7:0] REV_ID      = 8'h35
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_drive_low_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic       scl_f, sda_f;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic [1:0] line_in, line_out;

    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_rf_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_in[g]),
            .dout (line_out[g])
        );
    end

    assign scl_f = line_out[0];
    assign sda_f = line_out[1];

    i2c_rf_engine #(.NUM_REGS(NUM_REGS)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_f),
        .sda      (sda_f),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_drive(sda_drive_low_o)
    );

    i2c_rf_regbank #(.NUM_REGS(NUM_REGS), .REV_ID(REV_ID)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .regs_o (regs_o)
    );
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk #(
    parameter int NUM_REGS = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_f,
    input logic                  sda_f,
    input logic                  wr_en,
    input logic [7:0]            wr_addr,
    input logic                  sda_drive_low_o,
    input logic [NUM_REGS*8-1:0] regs_o
);
    p_drive_rise_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low_o) |-> !scl_f);

    p_drive_fall_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drive_low_o) |-> !scl_f);

    p_regs_change_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> !$past(scl_f));

    p_reserved_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < 8'(NUM_REGS)));

    p_release_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && sda_f && !$past(sda_f)) |=> !sda_drive_low_o);
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_f          (scl_f),
    .sda_f          (sda_f),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .sda_drive_low_o(sda_drive_low_o),
    .regs_o         (regs_o)
);

// File: tb/i2c_regfile_slave_test.sv
module i2c_regfile_slave_test;
    localparam int         CLK_PERIOD = 10;
    localparam int         NREG       = 10;
    localparam logic [7:0] REV        = 8'h35;
    localparam int         Q          = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drv;
    logic [NREG*8-1:0] regs;
    logic sda_bus;

    int n_checks = 0;
    int n_fail   = 0;
    int r12_viol = 0;
    logic [7:0] mdl [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = sda_m & ~sda_drv;

    i2c_regfile_slave #(.NUM_REGS(NREG), .REV_ID(REV)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_drive_low_o(sda_drv), .regs_o(regs)
    );

    // R12 monitor: drive must not move while the bus clock is high
    logic drv_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_drv != drv_prev && scl_m) r12_viol++;
        drv_prev <= sda_drv;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] p);
        if (p < NREG) return mdl[p];
        if (p == 8'hFF) return REV;
        return 8'h00;
    endfunction

    function automatic logic [7:0] reg_at(input int i);
        return regs[i*8 +: 8];
    endfunction

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; wc(Q);
            scl_m = 1'b1; wc(Q);
        end
        sda_m = 1'b0; wc(Q);
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wc(Q);
        scl_m = 1'b1; wc(Q);
        sda_m = 1'b1; wc(2*Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_m = b;
        if (glitch) begin
            wc(4); scl_m = 1'b1; wc(2); scl_m = 1'b0; wc(Q-6);
        end else begin
            wc(Q);
        end
        scl_m = 1'b1; wc(2*Q);
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && i == 4);
        sda_m = 1'b1; wc(Q);
        scl_m = 1'b1; wc(Q);
        ack = ~sda_bus;
        wc(Q);
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic read_byte(input bit ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wc(Q);
            scl_m = 1'b1; wc(Q);
            b[i] = sda_bus;
            wc(Q);
            scl_m = 1'b0; wc(Q);
        end
        send_bit(~ack, 1'b0);
        sda_m = 1'b1;
    endtask

    // write transaction with model update
    task automatic wr_txn(input logic [7:0] p, input logic [7:0] d0, input int len, input string tag);
        bit a;
        logic [7:0] ptr = p;
        bus_start();
        write_byte(8'h9A, 1'b0, a); chk(a, {tag, " addr ack R2 R3"}, a, 1);
        write_byte(p, 1'b0, a);     chk(a, {tag, " ptr ack R3"}, a, 1);
        for (int k = 0; k < len; k++) begin
            logic [7:0] v = d0 + 8'(k * 37);
            write_byte(v, 1'b0, a); chk(a, {tag, " data ack R3 R10"}, a, 1);
            if (ptr < NREG) mdl[ptr] = v;
            ptr++;
        end
        bus_stop();
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(reg_at(i) == mdl[i], {tag, " R4 register value"}, reg_at(i), mdl[i]);
    endtask

    // preset pointer, repeated start, read len bytes
    task automatic rd_txn(input logic [7:0] p, input int len, input string tag);
        bit a;
        logic [7:0] b;
        logic [7:0] ptr = p;
        bus_start();
        write_byte(8'h9A, 1'b0, a);
        write_byte(p, 1'b0, a);
        bus_start();
        write_byte(8'h9B, 1'b0, a); chk(a, {tag, " read addr ack R2"}, a, 1);
        for (int k = 0; k < len; k++) begin
            read_byte(k != len-1, b);
            chk(b == exp_rd(ptr), {tag, " R6 R10 read byte"}, b, exp_rd(ptr));
            ptr++;
        end
        chk(sda_drv == 1'b0, {tag, " R7 released after NACK"}, sda_drv, 0);
        bus_stop();
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        void'($urandom(32'd4711));
        wc(5);
        rst_n = 1'b1;
        wc(10);

        // R1 reset state
        check_bank("reset R1");
        chk(sda_drv == 1'b0, "R1 SDA idle", sda_drv, 0);

        // directed write of four registers
        wr_txn(8'h00, 8'h11, 4, "basic");
        check_bank("basic");

        // R2 foreign address ignored
        bus_start();
        write_byte(8'h9C, 1'b0, a); chk(!a, "R2 foreign addr no ack", a, 0);
        write_byte(8'h00, 1'b0, a); chk(!a, "R2 foreign ptr no ack", a, 0);
        write_byte(8'hEE, 1'b0, a);
        bus_stop();
        check_bank("R2 foreign");

        // R5 pointer set then STOP, fresh START read begins at 0
        bus_start();
        write_byte(8'h9A, 1'b0, a);
        write_byte(8'h03, 1'b0, a);
        bus_stop();
        bus_start();
        write_byte(8'h9B, 1'b0, a); chk(a, "R5 read addr ack", a, 1);
        read_byte(1'b1, b); chk(b == mdl[0], "R5 first byte reg0", b, mdl[0]);
        read_byte(1'b0, b); chk(b == mdl[1], "R7 ack continues", b, mdl[1]);
        chk(sda_drv == 1'b0, "R7 NACK release", sda_drv, 0);
        bus_stop();

        // R6 repeated start read from preset pointer
        rd_txn(8'h02, 3, "R6 preset");

        // R4/R10 wrap through reserved space
        wr_txn(8'h09, 8'h77, 2, "R10 span");
        wr_txn(8'hFF, 8'h99, 2, "R4 wrap");
        check_bank("R4 wrap");
        rd_txn(8'hFE, 3, "R10 reserved read");

        // R8 early stop mid data byte
        bus_start();
        write_byte(8'h9A, 1'b0, a);
        write_byte(8'h05, 1'b0, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        bus_stop();
        chk(sda_drv == 1'b0, "R8 released on stop", sda_drv, 0);
        check_bank("R8 early stop");
        wr_txn(8'h05, 8'h5C, 1, "R8 after abort");
        check_bank("R8 after abort");

        // R9 stop in same high as start is ignored
        sda_m = 1'b0; wc(Q);
        sda_m = 1'b1; wc(Q);
        scl_m = 1'b0; wc(Q);
        write_byte(8'h9A, 1'b0, a); chk(a, "R9 transfer continues", a, 1);
        write_byte(8'h06, 1'b0, a);
        write_byte(8'hC3, 1'b0, a);
        mdl[6] = 8'hC3;
        bus_stop();
        check_bank("R9");

        // R11 short SCL spike inside a data byte
        bus_start();
        write_byte(8'h9A, 1'b0, a);
        write_byte(8'h07, 1'b0, a);
        write_byte(8'h6B, 1'b1, a); chk(a, "R11 ack despite spike", a, 1);
        mdl[7] = 8'h6B;
        bus_stop();
        check_bank("R11 spike");

        // random mix
        for (int it = 0; it < 8; it++) begin
            logic [7:0] p  = (it % 4 == 3) ? 8'(8'hFC + $urandom_range(0, 3)) : 8'($urandom_range(0, NREG-1));
            logic [7:0] d0 = 8'($urandom);
            int len = $urandom_range(1, 3);
            wr_txn(p, d0, len, "rand wr");
            check_bank("rand");
            rd_txn(8'($urandom_range(0, NREG-1)), $urandom_range(1, 3), "rand rd");
        end

        chk(r12_viol == 0, "R12 drive changes only while SCL low", r12_viol, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule